// File: doc/BRIEF.md
# USB Full-Speed Receive Front End

This block turns the two data lines of a USB full-speed pair into a stream of bytes. It runs on a system clock that has no fixed relation to the 12 Mbit/s line rate. A 16-bit phase accumulator adds a programmable increment on every clock. When the accumulator carries, the line is sampled. Every change of line state reloads the accumulator to its half-scale value, so each sample lands near the middle of a bit, and the timing locks again on every transition in the packet.

Each sample is classified as J, K, single-ended zero or an illegal state. The NRZI code is then decoded and stuff bits are removed. A framer looks for the sync pattern, builds bytes from the continuous bitstream and detects end of packet. It reports each finished byte with a one-cycle strobe. Packet start, packet end and error are also one-cycle pulses. CRC, PID and transaction handling belong to the logic that consumes these outputs.

Top module: `fs_rx_front`

## Requirements
- R1: The line state is taken as {dm_i, dp_i}: 01 is J, 10 is K, 00 is SE0 and 11 is illegal. An illegal sample in any state except abort gives a one-cycle err_o pulse and aborts the packet.
- R2: When the accumulator carries, the line is sampled. An increment of 65536/N gives one sample per N clocks, placed near the bit centre after a transition. The bench checks this for N = 8 (increment 8192) and N = 10 (increment 6554).
- R3: A line transition reloads the accumulator to half scale. A transition in the same cycle as a carry suppresses that sample, so a bit stretched up to 1.5 periods, or shrunk to 5/8 of a period, is still decoded exactly once.
- R4: NRZI decode: two equal consecutive J/K samples give a 1, and a change between them gives a 0. After idle, the previous level is taken as J.
- R5: A packet starts when seven decoded zeros are followed by a one, the first zero being the K that leaves idle. pkt_start_o then pulses once. Any other pattern aborts silently and raises no pulse.
- R6: Payload bits are assembled least significant bit first. Each group of eight gives byte_o with a one-cycle byte_valid_o.
- R7: After six consecutive decoded ones, the next bit is a stuff zero and is dropped. The final one of the sync counts toward the run, and the run carries across byte boundaries.
- R8: If a one arrives where a stuff zero is due, err_o pulses once. Nothing further is reported until a J sample and then a new sync.
- R9: Two consecutive SE0 samples inside a packet give one pkt_end_o pulse. A single SE0 sample followed by J or K gives err_o and an abort.
- R10: SE0 on an idle line is ignored. A partial byte pending at end of packet is discarded.
- R11: After reset all outputs are zero, and at most one of byte_valid_o, pkt_start_o, pkt_end_o and err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dp_i | input | 1 | Synchronised D+ level |
| dm_i | input | 1 | Synchronised D- level |
| phase_inc_i | input | 16 | Increment added to the phase accumulator every clock |
| byte_o | output | 8 | Last assembled byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |
| pkt_start_o | output | 1 | One-cycle pulse after a valid sync |
| pkt_end_o | output | 1 | One-cycle pulse at end of packet |
| err_o | output | 1 | One-cycle pulse on stuff error, illegal state or short SE0 |

## Verification
Two pairs of events can fall in the same cycle. The first is a line transition arriving exactly when the accumulator carries. The bench provokes it by sending a run of zero bits whose lengths alternate between 12 and 5 clocks, so every second edge lands on a due sample. The result is judged by the bytes still decoding to the values sent. The second is a stuff bit dropped in the sample straight after a byte completes: the byte 0xFC followed by 0x00 has its run of six ones end on the byte boundary, and the scoreboard expects both bytes unchanged with no error.

// File: rtl/fsrx_pkg.sv
package fsrx_pkg;
  // encoded as {dm, dp}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_SYNC,
    FR_DATA,
    FR_ABORT
  } fr_state_e;
endpackage

// File: rtl/fsrx_line.sv
module fsrx_line
  import fsrx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  dp_i,
  input  logic  dm_i,
  output line_e line_o,
  output logic  edge_o
);
  line_e st_q;

  assign line_o = line_e'({dm_i, dp_i});
  assign edge_o = (line_o != st_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= LS_J;
    else         st_q <= line_o;
  end
endmodule

// File: rtl/fsrx_nco.sv
module fsrx_nco #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  input  logic             edge_i,
  output logic             sample_o
);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (ACC_W - 1);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum      = {1'b0, acc_q} + {1'b0, inc_i};
  // an edge takes priority over a due carry
  assign sample_o = sum[ACC_W] & ~edge_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (edge_i) acc_q <= HALF;
    else             acc_q <= sum[ACC_W-1:0];
  end

  // R2
  wrap_residue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (acc_q < $past(inc_i)));
endmodule

// File: rtl/fsrx_destuff.sv
module fsrx_destuff
  import fsrx_pkg::*;
#(
  parameter int RUN_MAX = 6
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  smp_i,
  input  line_e line_i,
  input  logic  clr_i,
  output logic  bit_vld_o,
  output logic  bit_o,
  output logic  stuff_err_o
);
  localparam int RUN_W = $clog2(RUN_MAX + 1);

  line_e            prev_q, prev_eff;
  logic [RUN_W-1:0] run_q, run_eff;
  logic             is_data, dec, at_stuff;

  assign is_data     = smp_i && (line_i == LS_J || line_i == LS_K);
  assign prev_eff    = clr_i ? LS_J : prev_q;
  assign run_eff     = clr_i ? '0 : run_q;
  assign dec         = (line_i == prev_eff);
  assign at_stuff    = (run_eff == RUN_W'(RUN_MAX));
  assign bit_vld_o   = is_data && !at_stuff;
  assign bit_o       = dec;
  assign stuff_err_o = is_data && at_stuff && dec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= LS_J;
      run_q  <= '0;
    end else if (is_data) begin
      prev_q <= line_i;
      if (at_stuff || !dec) run_q <= '0;
      else                  run_q <= run_eff + RUN_W'(1);
    end else if (clr_i) begin
      prev_q <= LS_J;
      run_q  <= '0;
    end
  end

  // R7
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(RUN_MAX));
endmodule

// File: rtl/fsrx_framer.sv
module fsrx_framer
  import fsrx_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int SYNC_ZEROS = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_i,
  input  line_e             line_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              stuff_err_i,
  output logic              clr_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              pkt_start_o,
  output logic              pkt_end_o,
  output logic              err_o
);
  localparam int CNT_MAX = (BYTE_W > SYNC_ZEROS) ? BYTE_W : SYNC_ZEROS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  fr_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, sh_nxt;
  logic              se0_q;
  logic              is_se0, is_se1;

  assign is_se0 = smp_i && (line_i == LS_SE0);
  assign is_se1 = smp_i && (line_i == LS_SE1);
  assign clr_o  = (st_q == FR_IDLE) || (st_q == FR_ABORT);
  assign sh_nxt = {bit_i, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= FR_IDLE;
      cnt_q        <= '0;
      sh_q         <= '0;
      se0_q        <= 1'b0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
      pkt_start_o  <= 1'b0;
      pkt_end_o    <= 1'b0;
      err_o        <= 1'b0;
    end else begin
      byte_valid_o <= 1'b0;
      pkt_start_o  <= 1'b0;
      pkt_end_o    <= 1'b0;
      err_o        <= 1'b0;
      unique case (st_q)
        FR_IDLE: begin
          if (is_se1) begin
            err_o <= 1'b1;
            st_q  <= FR_ABORT;
          end else if (bit_vld_i && !bit_i) begin
            st_q  <= FR_SYNC;
            cnt_q <= CNT_W'(1);
          end
        end
        FR_SYNC: begin
          if (is_se1 || stuff_err_i) begin
            err_o <= 1'b1;
            st_q  <= FR_ABORT;
          end else if (is_se0) begin
            st_q <= FR_IDLE;
          end else if (bit_vld_i) begin
            if (!bit_i) begin
              if (cnt_q == CNT_W'(SYNC_ZEROS)) st_q <= FR_ABORT;
              else                             cnt_q <= cnt_q + CNT_W'(1);
            end else if (cnt_q == CNT_W'(SYNC_ZEROS)) begin
              st_q        <= FR_DATA;
              pkt_start_o <= 1'b1;
              cnt_q       <= '0;
              se0_q       <= 1'b0;
            end else begin
              st_q <= FR_ABORT;
            end
          end
        end
        FR_DATA: begin
          if (is_se1 || stuff_err_i) begin
            err_o <= 1'b1;
            st_q  <= FR_ABORT;
          end else if (is_se0) begin
            if (se0_q) begin
              pkt_end_o <= 1'b1;
              st_q      <= FR_IDLE;
            end else begin
              se0_q <= 1'b1;
            end
          end else if (smp_i && se0_q) begin
            // SE0 shorter than two bit times
            err_o <= 1'b1;
            st_q  <= FR_ABORT;
          end else if (bit_vld_i) begin
            sh_q <= sh_nxt;
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              byte_o       <= sh_nxt;
              byte_valid_o <= 1'b1;
              cnt_q        <= '0;
            end else begin
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        FR_ABORT: begin
          if (smp_i && line_i == LS_J) st_q <= FR_IDLE;
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  // R11
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({byte_valid_o, pkt_start_o, pkt_end_o, err_o}));
  // R5
  start_enters_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> (st_q == FR_DATA));
  // R1
  illegal_state_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_se1 && st_q != FR_ABORT) |=> err_o);
  // R6
  byte_only_in_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> ($past(st_q) == FR_DATA));
endmodule

// File: rtl/fs_rx_front.sv
module fs_rx_front
  import fsrx_pkg::*;
#(
  parameter int ACC_W      = 16,
  parameter int BYTE_W     = 8,
  parameter int SYNC_ZEROS = 7,
  parameter int RUN_MAX    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dp_i,
  input  logic              dm_i,
  input  logic [ACC_W-1:0]  phase_inc_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              pkt_start_o,
  output logic              pkt_end_o,
  output logic              err_o
);
  line_e line;
  logic  line_edge, smp, clr, bit_vld, bit_val, stuff_err;

  fsrx_line u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dp_i   (dp_i),
    .dm_i   (dm_i),
    .line_o (line),
    .edge_o (line_edge)
  );

  fsrx_nco #(.ACC_W(ACC_W)) u_nco (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (phase_inc_i),
    .edge_i   (line_edge),
    .sample_o (smp)
  );

  fsrx_destuff #(.RUN_MAX(RUN_MAX)) u_destuff (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .smp_i       (smp),
    .line_i      (line),
    .clr_i       (clr),
    .bit_vld_o   (bit_vld),
    .bit_o       (bit_val),
    .stuff_err_o (stuff_err)
  );

  fsrx_framer #(.BYTE_W(BYTE_W), .SYNC_ZEROS(SYNC_ZEROS)) u_framer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .smp_i        (smp),
    .line_i       (line),
    .bit_vld_i    (bit_vld),
    .bit_i        (bit_val),
    .stuff_err_i  (stuff_err),
    .clr_o        (clr),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .pkt_start_o  (pkt_start_o),
    .pkt_end_o    (pkt_end_o),
    .err_o        (err_o)
  );

  // R9
  eop_from_se0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_o |-> (!$past(dp_i) && !$past(dm_i)));
endmodule

// File: tb/sim_fs_rx_front.sv
module sim_fs_rx_front;
  localparam int K_START = 1, K_BYTE = 2, K_END = 3, K_ERR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dp = 1'b1, dm = 1'b0;
  logic [15:0] inc = 16'd8192;
  logic [7:0]  byte_o;
  logic        byte_valid, pkt_start, pkt_end, err;

  int checks = 0;
  int fails  = 0;
  int bp     = 8;
  logic [1:0] lvl = 2'b01;
  int run    = 0;
  bit jl     = 1'b0;

  int    exp_kind[$];
  int    exp_data[$];
  string exp_req[$];

  always #5 clk = ~clk;

  fs_rx_front u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .dp_i         (dp),
    .dm_i         (dm),
    .phase_inc_i  (inc),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid),
    .pkt_start_o  (pkt_start),
    .pkt_end_o    (pkt_end),
    .err_o        (err)
  );

  function automatic string kname(int k);
    case (k)
      K_START: return "START";
      K_BYTE:  return "BYTE";
      K_END:   return "END";
      default: return "ERR";
    endcase
  endfunction

  task automatic push(int k, int d, string req);
    exp_kind.push_back(k);
    exp_data.push_back(d);
    exp_req.push_back(req);
  endtask

  task automatic got(int k, int d);
    int ek, ed;
    string r;
    checks++;
    if (exp_kind.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: got %s 0x%02h, expected none", kname(k), d);
    end else begin
      ek = exp_kind.pop_front();
      ed = exp_data.pop_front();
      r  = exp_req.pop_front();
      if (ek != k || ed != d) begin
        fails++;
        $display("FAIL %s: got %s 0x%02h, expected %s 0x%02h", r, kname(k), d, kname(ek), ed);
      end
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_start)  got(K_START, 0);
      if (byte_valid) got(K_BYTE, int'(byte_o));
      if (pkt_end)    got(K_END, 0);
      if (err)        got(K_ERR, 0);
    end
  end

  task automatic drv(logic [1:0] ls, int cyc);
    {dm, dp} = ls;
    repeat (cyc) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(bit b, int cyc);
    if (!b) lvl = ~lvl;
    drv(lvl, cyc);
  endtask

  task automatic send_sync();
    lvl = 2'b01;
    for (int i = 0; i < 7; i++) send_bit(1'b0, bp);
    send_bit(1'b1, bp);
    run = 1;
  endtask

  task automatic send_byte(logic [7:0] b, bit stuff_en, bit jit);
    for (int i = 0; i < 8; i++) begin
      int cyc;
      cyc = bp;
      if (jit && !b[i]) begin
        cyc = jl ? 12 : 5;
        jl = ~jl;
      end
      send_bit(b[i], cyc);
      if (b[i]) run++;
      else      run = 0;
      if (stuff_en && run == 6) begin
        send_bit(1'b0, bp);
        run = 0;
      end
    end
  endtask

  task automatic send_eop();
    drv(2'b00, 2 * bp);
    lvl = 2'b01;
    drv(lvl, 8 * bp);
  endtask

  task automatic settle(string req);
    repeat (4 * bp) @(posedge clk);
    #1;
    checks++;
    if (exp_kind.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d events missing, next expected %s 0x%02h",
               req, exp_kind.size(), kname(exp_kind[0]), exp_data[0]);
      exp_kind.delete();
      exp_data.delete();
      exp_req.delete();
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    checks++;
    if (byte_valid || pkt_start || pkt_end || err || byte_o != 8'h00) begin
      fails++;
      $display("FAIL R11: reset outputs %b%b%b%b 0x%02h, expected 0000 0x00",
               byte_valid, pkt_start, pkt_end, err, byte_o);
    end
    rst_n = 1'b1;
    drv(2'b01, 8 * bp);

    // R10 SE0 on idle line ignored
    drv(2'b00, bp);
    drv(2'b01, 8 * bp);
    settle("R10");

    // R4 R6 plain packet
    push(K_START, 0, "R5"); push(K_BYTE, 8'hA5, "R6"); push(K_BYTE, 8'h3C, "R4"); push(K_END, 0, "R9");
    send_sync(); send_byte(8'hA5, 1, 0); send_byte(8'h3C, 1, 0); send_eop();
    settle("R6");

    // R7 stuffing, incl. a stuff bit right after a byte boundary
    push(K_START, 0, "R5"); push(K_BYTE, 8'hFC, "R7"); push(K_BYTE, 8'h00, "R7");
    push(K_BYTE, 8'hFF, "R7"); push(K_BYTE, 8'hFF, "R7"); push(K_END, 0, "R9");
    send_sync(); send_byte(8'hFC, 1, 0); send_byte(8'h00, 1, 0);
    send_byte(8'hFF, 1, 0); send_byte(8'hFF, 1, 0); send_eop();
    settle("R7");

    // R3 edges colliding with due samples
    jl = 1'b1;
    push(K_START, 0, "R3"); push(K_BYTE, 8'h00, "R3"); push(K_BYTE, 8'h00, "R3"); push(K_END, 0, "R3");
    send_sync(); send_byte(8'h00, 1, 1); send_byte(8'h00, 1, 1); send_eop();
    settle("R3");

    // R8 missing stuff bit
    push(K_START, 0, "R5"); push(K_ERR, 0, "R8");
    send_sync(); send_byte(8'hFF, 0, 0); send_byte(8'hFF, 0, 0); send_eop();
    settle("R8");
    push(K_START, 0, "R8"); push(K_BYTE, 8'h12, "R8"); push(K_END, 0, "R8");
    send_sync(); send_byte(8'h12, 1, 0); send_eop();
    settle("R8");

    // R1 illegal line state mid-packet
    push(K_START, 0, "R5"); push(K_BYTE, 8'h55, "R6"); push(K_ERR, 0, "R1");
    send_sync(); send_byte(8'h55, 1, 0); drv(2'b11, bp); send_eop();
    settle("R1");

    // R9 single-bit SE0
    push(K_START, 0, "R5"); push(K_BYTE, 8'h81, "R6"); push(K_ERR, 0, "R9");
    send_sync(); send_byte(8'h81, 1, 0); drv(2'b00, bp); lvl = 2'b01; drv(lvl, 8 * bp);
    settle("R9");

    // R5 bad sync: five zeros then a one
    lvl = 2'b01;
    for (int i = 0; i < 5; i++) send_bit(1'b0, bp);
    send_bit(1'b1, bp);
    send_bit(1'b1, bp);
    lvl = 2'b01; drv(lvl, 8 * bp);
    settle("R5");

    // R10 partial byte dropped at end of packet
    push(K_START, 0, "R5"); push(K_BYTE, 8'h77, "R10"); push(K_END, 0, "R10");
    send_sync(); send_byte(8'h77, 1, 0);
    send_bit(1'b0, bp); send_bit(1'b1, bp); send_bit(1'b0, bp);
    send_eop();
    settle("R10");

    // R2 other increment: 10 clocks per bit
    bp  = 10;
    inc = 16'd6554;
    drv(2'b01, 8 * bp);
    push(K_START, 0, "R2"); push(K_BYTE, 8'h5A, "R2"); push(K_BYTE, 8'hC3, "R2"); push(K_END, 0, "R2");
    send_sync(); send_byte(8'h5A, 1, 0); send_byte(8'hC3, 1, 0); send_eop();
    settle("R2");

    finish_run();
  end
endmodule